// File: doc/BRIEF.md
# Blit Direction Setup

This block sits in front of a 2D drawing engine. It turns one rectangle request (copy or fill) into the words the engine needs to start work: the source start point, the destination start point, the size, and a control word. The control word holds the traversal direction flags, a last-pixel flag and, in 24 bits-per-pixel mode, a byte rotation phase.

For a copy, the block picks the walking direction from the position of the source relative to the destination. An overlapping copy then never reads a pixel it has already overwritten. When a direction is reversed, the start point moves to the far edge of the rectangle. In 24-bit mode the engine works on bytes, so every horizontal quantity is tripled before any of this logic runs. The rotation phase is then taken from the final destination x.

Requests arrive on a valid/ready handshake. Results leave through a single output register with its own valid/ready handshake. A request with zero width or zero height is consumed and produces nothing.

Top module: `blit_dir_setup`

## Requirements
- R1: `req_ready` is high exactly when the output register is empty or `out_ready` is high. A non-empty request accepted on a clock edge makes `out_valid` high after that edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and all output words hold their values.
- R3: An accepted request whose width or height is zero produces no output.
- R4: When `req_bpp24` is 1, source x, destination x and width are multiplied by 3, modulo 2^16, before direction and rotation are worked out. Y values and height are never scaled.
- R5: For a copy (`req_op`=1) with source y < destination y, height-1 is added to both y values and the y flag (control bit 1) is 0, meaning bottom-to-top. Otherwise the flag is 1, meaning top-to-bottom, and the y values pass unchanged.
- R6: For a copy with scaled source x < scaled destination x, scaled width-1 is added to both x values and the x flag (control bit 0) is 0, meaning right-to-left. Otherwise the flag is 1, meaning left-to-right.
- R7: A fill (`req_op`=0) sets both direction flags to 1 and outputs a source word of 0.
- R8: In 24-bit mode, control bits [10:8] carry (dx/4) mod 6 when the x flag is 1 and ((dx+2)/4) mod 6 when it is 0, where dx is the final destination x. Bit 11 is 1 in this mode. Outside 24-bit mode, bits [11:8] are 0.
- R9: Each coordinate word packs x in bits [31:16] and y in bits [15:0]. The size word packs scaled width in [31:16] and height in [15:0]. All sums are taken modulo 2^16.
- R10: Control bit 5 (last pixel) is always 1. Control bits [15:12], [7:6] and [4:2] are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 1 | 1 = copy, 0 = fill |
| req_bpp24 | input | 1 | 24 bits-per-pixel mode |
| req_sx | input | 16 | Source x |
| req_sy | input | 16 | Source y |
| req_dx | input | 16 | Destination x |
| req_dy | input | 16 | Destination y |
| req_w | input | 16 | Width in pixels |
| req_h | input | 16 | Height in lines |
| out_valid | output | 1 | Output words valid |
| out_ready | input | 1 | Consumer takes the output |
| out_src | output | 32 | Source start {x, y} |
| out_dst | output | 32 | Destination start {x, y} |
| out_size | output | 32 | {width, height} |
| out_ctrl | output | 16 | Direction, last-pixel and rotation control |

## Verification
The assertions check the properties that hold on every cycle. These are output holding under backpressure, dropping of empty requests, a valid output following a non-empty accept, the fill flags with a zero source word, the last-pixel bit, and the rotation field staying below 6 and being zero when disabled. Exact values need the scoreboard scenarios: scaled coordinates, far-edge start points for each overlap case, wraparound at 2^16, and each rotation phase for both walking directions. The ordering of results under random backpressure also relies on the scoreboard.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic {
    OP_FILL = 1'b0,
    OP_COPY = 1'b1
  } blit_op_e;

  localparam int CTRL_W     = 16;
  localparam int BIT_XFWD   = 0;
  localparam int BIT_YFWD   = 1;
  localparam int BIT_LAST   = 5;
  localparam int ROT_LSB    = 8;
  localparam int BIT_ROT_EN = 11;

endpackage

// File: rtl/blit_xform.sv
module blit_xform #(
  parameter int CW = 16
) (
  input  logic          is_copy,
  input  logic          bpp24,
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  input  logic [CW-1:0] dx,
  input  logic [CW-1:0] dy,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  output logic [CW-1:0] src_x,
  output logic [CW-1:0] src_y,
  output logic [CW-1:0] dst_x,
  output logic [CW-1:0] dst_y,
  output logic [CW-1:0] size_w,
  output logic          x_fwd,
  output logic          y_fwd
);

  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] scale3(input logic [CW-1:0] v, input logic en);
    logic [CW-1:0] t;
    t = (v << 1) + v;
    return en ? t : v;
  endfunction

  function automatic logic [CW-1:0] far_edge(input logic [CW-1:0] base,
                                             input logic [CW-1:0] len);
    return base + len - ONE;
  endfunction

  logic [CW-1:0] sxa, dxa, wa;

  always_comb begin
    sxa    = scale3(sx, bpp24);
    dxa    = scale3(dx, bpp24);
    wa     = scale3(w, bpp24);
    y_fwd  = !(is_copy && (sy < dy));
    x_fwd  = !(is_copy && (sxa < dxa));
    src_x  = is_copy ? (x_fwd ? sxa : far_edge(sxa, wa)) : '0;
    src_y  = is_copy ? (y_fwd ? sy : far_edge(sy, h)) : '0;
    dst_x  = x_fwd ? dxa : far_edge(dxa, wa);
    dst_y  = y_fwd ? dy : far_edge(dy, h);
    size_w = wa;
  end

endmodule

// File: rtl/blit_rot.sv
module blit_rot #(
  parameter int CW     = 16,
  parameter int PHASES = 6,
  parameter int RW     = $clog2(PHASES)
) (
  input  logic [CW-1:0] dst_x,
  input  logic          x_fwd,
  output logic [RW-1:0] phase
);

  localparam logic [CW:0] PH  = (CW+1)'(PHASES);
  localparam logic [CW:0] TWO = (CW+1)'(2);

  function automatic logic [RW-1:0] phase_of(input logic [CW:0] v);
    logic [CW:0] q;
    q = (v >> 2) % PH;
    return q[RW-1:0];
  endfunction

  logic [CW:0] biased;

  always_comb begin
    biased = {1'b0, dst_x} + (x_fwd ? '0 : TWO);
    phase  = phase_of(biased);
  end

endmodule

// File: rtl/blit_out_reg.sv
module blit_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         drain,
  output logic         valid,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (drain) valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/blit_dir_setup.sv
module blit_dir_setup
  import blit_pkg::*;
#(
  parameter int CW     = 16,
  parameter int PHASES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_bpp24,
  input  logic [CW-1:0]     req_sx,
  input  logic [CW-1:0]     req_sy,
  input  logic [CW-1:0]     req_dx,
  input  logic [CW-1:0]     req_dy,
  input  logic [CW-1:0]     req_w,
  input  logic [CW-1:0]     req_h,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*CW-1:0]   out_src,
  output logic [2*CW-1:0]   out_dst,
  output logic [2*CW-1:0]   out_size,
  output logic [CTRL_W-1:0] out_ctrl
);

  localparam int WW    = 2 * CW;
  localparam int ROT_W = $clog2(PHASES);
  localparam int PKT_W = 3 * WW + CTRL_W;

  // named events for the checker
  logic acc_fire, acc_empty, acc_load;
  logic is_copy;

  assign req_ready = !out_valid || out_ready;
  assign acc_fire  = req_valid && req_ready;
  assign acc_empty = (req_w == '0) || (req_h == '0);
  assign acc_load  = acc_fire && !acc_empty;
  assign is_copy   = (req_op == OP_COPY);

  logic [CW-1:0]    src_x, src_y, dst_x, dst_y, size_w;
  logic             x_fwd, y_fwd;
  logic [ROT_W-1:0] rot;

  blit_xform #(.CW(CW)) u_xform (
    .is_copy (is_copy),
    .bpp24   (req_bpp24),
    .sx      (req_sx),
    .sy      (req_sy),
    .dx      (req_dx),
    .dy      (req_dy),
    .w       (req_w),
    .h       (req_h),
    .src_x   (src_x),
    .src_y   (src_y),
    .dst_x   (dst_x),
    .dst_y   (dst_y),
    .size_w  (size_w),
    .x_fwd   (x_fwd),
    .y_fwd   (y_fwd)
  );

  blit_rot #(.CW(CW), .PHASES(PHASES), .RW(ROT_W)) u_rot (
    .dst_x (dst_x),
    .x_fwd (x_fwd),
    .phase (rot)
  );

  logic [CTRL_W-1:0] ctrl;

  always_comb begin
    ctrl           = '0;
    ctrl[BIT_XFWD] = x_fwd;
    ctrl[BIT_YFWD] = y_fwd;
    ctrl[BIT_LAST] = 1'b1;
    if (req_bpp24) begin
      ctrl[ROT_LSB +: ROT_W] = rot;
      ctrl[BIT_ROT_EN]       = 1'b1;
    end
  end

  logic [PKT_W-1:0] pkt_in, pkt_out;

  assign pkt_in = {src_x, src_y, dst_x, dst_y, size_w, req_h, ctrl};

  blit_out_reg #(.W(PKT_W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (acc_load),
    .din   (pkt_in),
    .drain (out_ready),
    .valid (out_valid),
    .dout  (pkt_out)
  );

  assign {out_src, out_dst, out_size, out_ctrl} = pkt_out;

endmodule

// File: rtl/blit_dir_setup_chk.sv
module blit_dir_setup_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_fire,
  input logic          acc_empty,
  input logic          req_op,
  input logic          out_valid,
  input logic          out_ready,
  input logic [2*CW-1:0] out_src,
  input logic [2*CW-1:0] out_dst,
  input logic [2*CW-1:0] out_size,
  input logic [15:0]   out_ctrl
);

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_empty |=> out_valid);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_dst)
      && $stable(out_size) && $stable(out_ctrl));

  // R3
  empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && acc_empty |=> !out_valid);

  // R7
  fill_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_empty && !req_op |=> out_ctrl[1:0] == 2'b11 && out_src == '0);

  // R10
  last_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ctrl[5]);

  // R8
  rot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ctrl[10:8] < 3'd6);

  // R8
  rot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ctrl[11] |-> out_ctrl[10:8] == 3'd0);

endmodule

bind blit_dir_setup blit_dir_setup_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_fire  (acc_fire),
  .acc_empty (acc_empty),
  .req_op    (req_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_src   (out_src),
  .out_dst   (out_dst),
  .out_size  (out_size),
  .out_ctrl  (out_ctrl)
);

// File: tb/blit_dir_setup_bench.sv
module blit_dir_setup_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic        req_bpp24 = 1'b0;
  logic [15:0] req_sx = '0, req_sy = '0, req_dx = '0, req_dy = '0, req_w = '0, req_h = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_src, out_dst, out_size;
  logic [15:0] out_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_dir_setup u_blit_dir_setup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bpp24(req_bpp24), .req_sx(req_sx), .req_sy(req_sy),
    .req_dx(req_dx), .req_dy(req_dy), .req_w(req_w), .req_h(req_h),
    .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
    .out_dst(out_dst), .out_size(out_size), .out_ctrl(out_ctrl)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] size;
    logic [15:0] ctrl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    bp_mode = 1'b0;
  logic [7:0] lf = 8'hA5;

  // expected result worked out from the requirements
  function automatic exp_t model(bit copy, bit b24, int sx, int sy, int dx, int dy,
                                 int w, int h);
    exp_t m;
    int xs, xd, ww, ys, yd, rot, c;
    bit tx, ty;
    xs = b24 ? (sx * 3) % 65536 : sx;
    xd = b24 ? (dx * 3) % 65536 : dx;
    ww = b24 ? (w * 3) % 65536 : w;
    ys = sy;
    yd = dy;
    ty = !(copy && (sy < dy));
    if (!ty) begin
      ys = (ys + h - 1) % 65536;
      yd = (yd + h - 1) % 65536;
    end
    tx = !(copy && (xs < xd));
    if (!tx) begin
      xs = (xs + ww - 1) % 65536;
      xd = (xd + ww - 1) % 65536;
    end
    if (!copy) begin
      xs = 0;
      ys = 0;
    end
    rot = tx ? (xd / 4) % 6 : ((xd + 2) / 4) % 6;
    c = 32 + (ty ? 2 : 0) + (tx ? 1 : 0);
    if (b24) c = c + 2048 + rot * 256;
    m.src  = {xs[15:0], ys[15:0]};
    m.dst  = {xd[15:0], yd[15:0]};
    m.size = {ww[15:0], h[15:0]};
    m.ctrl = c[15:0];
    return m;
  endfunction

  task automatic send(bit copy, bit b24, int sx, int sy, int dx, int dy, int w, int h,
                      string tag);
    @(negedge clk);
    req_op = copy; req_bpp24 = b24;
    req_sx = 16'(sx); req_sy = 16'(sy); req_dx = 16'(dx); req_dy = 16'(dy);
    req_w = 16'(w); req_h = 16'(h);
    req_valid = 1'b1;
    #2;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    if (w != 0 && h != 0) begin
      exp_q.push_back(model(copy, b24, sx, sy, dx, dy, w, h));
      tag_q.push_back(tag);
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || out_valid) && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // monitor: drives out_ready, compares and checks holding
  logic        hold_pend = 1'b0;
  logic [31:0] h_src, h_dst, h_size;
  logic [15:0] h_ctrl;

  initial begin
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = bp_mode ? (lf[0] & lf[2]) : 1'b1;
      #1;
      if (rst_n) begin
        if (hold_pend) begin
          checks++;
          if (!out_valid || out_src != h_src || out_dst != h_dst ||
              out_size != h_size || out_ctrl != h_ctrl) begin
            errors++;
            $display("FAIL R2 hold: valid=%0b dst=%h ctrl=%h expected dst=%h ctrl=%h",
                     out_valid, out_dst, out_ctrl, h_dst, h_ctrl);
          end
        end
        hold_pend = out_valid && !out_ready;
        h_src = out_src; h_dst = out_dst; h_size = out_size; h_ctrl = out_ctrl;
        if (out_valid && out_ready) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3 unexpected output: dst=%h size=%h expected none",
                     out_dst, out_size);
          end else begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (out_src != e.src || out_dst != e.dst || out_size != e.size ||
                out_ctrl != e.ctrl) begin
              errors++;
              $display("FAIL %s: src=%h dst=%h size=%h ctrl=%h expected src=%h dst=%h size=%h ctrl=%h",
                       t, out_src, out_dst, out_size, out_ctrl, e.src, e.dst, e.size, e.ctrl);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #3;
    checks++;
    if (out_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: valid=%0b ready=%0b expected valid=0 ready=1", out_valid, req_ready);
    end
    rst_n = 1'b1;

    // R7 fill, 8-bit
    send(0, 0, 0, 0, 10, 20, 5, 7, "R7 fill");
    // R4 fill, 24-bit
    send(0, 1, 9, 9, 7, 3, 4, 2, "R4 fill scaled");
    // R5 copy downward overlap
    send(1, 0, 10, 10, 12, 14, 8, 4, "R5 copy bottom-up");
    // R6 copy up-left
    send(1, 0, 40, 30, 12, 14, 8, 4, "R6 copy forward");
    send(1, 0, 7, 7, 7, 7, 3, 3, "R6 equal coords");
    send(1, 0, 100, 5, 3, 9, 6, 6, "R6 mixed dirs");
    // R8 copy 24-bit reversed
    send(1, 1, 2, 0, 5, 0, 3, 1, "R8 copy24 reverse");
    // R9 packing
    send(1, 0, 16'h1234, 16'h0567, 16'h0089, 16'h0ABC, 16'h0011, 16'h0022, "R9 packing");
    // R4 wraparound
    send(1, 1, 30000, 1, 10, 2, 2, 2, "R4 wrap");
    send(1, 0, 65530, 65530, 0, 65535, 20, 3, "R9 wrap sum");
    for (int d = 0; d < 24; d++) send(0, 1, 0, 0, d, 1, 1, 1, "R8 fill phases");
    for (int d = 1; d < 13; d++) send(1, 1, 0, 0, d, 0, 2, 1, "R8 reverse phases");
    for (int d = 0; d < 4; d++) send(1, 0, 0, 0, d, 0, 1, 1, "R10 ctrl fixed bits");
    drain();

    // R3 empty requests
    send(1, 0, 1, 2, 3, 4, 0, 5, "R3 zero width");
    repeat (2) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R3 zero width: valid=%0b expected 0", out_valid);
    end
    send(0, 1, 1, 2, 3, 4, 5, 0, "R3 zero height");
    repeat (2) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R3 zero height: valid=%0b expected 0", out_valid);
    end
    send(0, 0, 0, 0, 1, 1, 1, 1, "R3 after empty");

    // R2 and R1 under backpressure
    bp_mode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send(i[0], i[1], (i * 37) % 200, (i * 11) % 90, (i * 53) % 200, (i * 29) % 90,
           (i % 7 == 3) ? 0 : 1 + i % 13, 1 + i % 5, "R1 backpressure");
    end
    drain();
    bp_mode = 1'b0;
    repeat (3) @(negedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 outstanding: %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule